// File: doc/BRIEF.md
# Serial Port Register Block with Error Status

This block is a memory-mapped asynchronous serial port. It transmits and receives 8-bit characters framed by one low start bit and one high stop bit, with no parity bit. Software uses it through a register bus with a 3-bit offset. There is one receive holding register and one transmit holding register, each single-entry. A 9-bit status word reports the ready flags and the error conditions. A control register holds one interrupt enable for each status flag, at the same bit position as that flag. A 16-bit divisor register sets the bit time in clock cycles.

On the receive side, the block finds a start edge and waits half a bit time. It then samples each bit at its midpoint, using a counter loaded from the divisor. On the transmit side, a byte written to the transmit register moves into a shift register as soon as the shift register is idle. Error flags stay set until software writes to the status register. A single interrupt output is raised while any enabled status flag is set.

Top module: `uart_regs`

## Requirements
- R1: Offset 0 reads the last received byte in bits 7:0. Offset 3 reads back the 9-bit control value. Offset 4 reads back the 16-bit divisor. Offsets 1, 5, 6 and 7 read as zero.
- R2: After reset, status reads 0x060 (TRDY and TMT set), control reads 0 and the divisor reads DIV_INIT (default 16).
- R3: Each status bit has a fixed position: bit 8 E, bit 7 RRDY, bit 6 TRDY, bit 5 TMT, bit 4 TOE, bit 3 ROE, bit 2 BRK, bit 1 FE, bit 0 PE.
- R4: A write to offset 1 sends the byte on txd. The start bit is low and lasts exactly one divisor's worth of clocks. The data bits follow LSB first, then a high stop bit.
- R5: TRDY is clear while the transmit holding register is full. TMT is set only when the holding register is empty and the shifter is idle. txd is high whenever TMT is set.
- R6: A write to offset 1 while TRDY is clear sets TOE. The written byte is discarded.
- R7: A received frame stores its byte and sets RRDY. A read of offset 0 clears RRDY.
- R8: A frame that completes while RRDY is still set sets ROE. The new byte replaces the old one.
- R9: A frame whose stop bit is sampled low sets FE.
- R10: A frame whose data bits and stop bit are all low sets BRK as well as FE.
- R11: E reads as the OR of TOE, ROE, BRK, FE and PE. Any write to offset 2 clears all five error flags and leaves RRDY, TRDY and TMT unchanged.
- R12: irq is high exactly when the status word ANDed with the control word is nonzero.
- R13: PE always reads 0, because frames carry no parity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle; a read of offset 0 consumes the byte |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the current offset (combinational) |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume three things. First, a read of offset 0 never lands in the same cycle as a frame completing. Second, the divisor is at least 2. Third, the divisor is not rewritten while a frame is in flight. The stimulus keeps to all three. Every register access starts on a falling clock edge, with a gap after each one. Serial frames are driven only while no character is being read. The divisor is set once to 12 before any traffic and is not changed afterwards.

// File: rtl/uart_regs.sv
module uart_regs #(
  parameter int DIV_W    = 16,
  parameter int DIV_INIT = 16,
  parameter bit HAS_DIV  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [DIV_W-1:0] wdata,
  output logic [DIV_W-1:0] rdata,
  input  logic             rxd,
  output logic             txd,
  output logic             irq
);
  localparam int DATA_W = 8;
  localparam int LAST   = DATA_W + 1;
  localparam int BIT_W  = $clog2(LAST + 1);
  localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(DIV_INIT);
  localparam logic [BIT_W-1:0] LAST_B  = BIT_W'(LAST);

  logic [DIV_W-1:0] div;
  logic [8:0] ctrl, status;
  logic rrdy, toe, roe, brk, fe, pe, trdy, tmt;
  logic [DATA_W-1:0] rx_data, rx_shift, txh;
  logic [1:0] rx_sync;
  logic rx_prev, rx_busy, txh_full, tx_busy;
  logic [DIV_W-1:0] rx_cnt, tx_cnt;
  logic [BIT_W-1:0] rx_bit, tx_bit;
  logic [DATA_W+1:0] tx_sh;

  wire rx_s   = rx_sync[1];
  wire fall   = rx_prev & ~rx_s;
  wire rx_end = rx_busy && rx_cnt == '0 && rx_bit == LAST_B;
  wire wr_tx  = wr_en && addr == 3'd1;
  wire wr_st  = wr_en && addr == 3'd2;
  wire rd_rx  = rd_en && addr == 3'd0;

  assign pe     = 1'b0;
  assign trdy   = ~txh_full;
  assign tmt    = ~txh_full & ~tx_busy;
  assign status = {toe | roe | brk | fe | pe, rrdy, trdy, tmt, toe, roe, brk, fe, pe};
  assign irq    = |(status & ctrl);
  assign txd    = tx_sh[0];

  generate
    if (HAS_DIV) begin : g_div
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) div <= DIV_RST;
        else if (wr_en && addr == 3'd4) div <= wdata;
    end else begin : g_fixed
      assign div = DIV_RST;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctrl <= '0;
    else if (wr_en && addr == 3'd3) ctrl <= wdata[8:0];

  always_comb begin
    rdata = '0;
    case (addr)
      3'd0: rdata[DATA_W-1:0] = rx_data;
      3'd2: rdata[8:0] = status;
      3'd3: rdata[8:0] = ctrl;
      3'd4: rdata = div;
      default: ;
    endcase
  end

  // receiver
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_sync <= 2'b11; rx_prev <= 1'b1; rx_busy <= 1'b0;
      rx_cnt <= '0; rx_bit <= '0; rx_shift <= '0;
    end else begin
      rx_sync <= {rx_sync[0], rxd};
      rx_prev <= rx_s;
      if (!rx_busy) begin
        if (fall) begin
          rx_busy <= 1'b1;
          rx_cnt  <= (div >> 1) - DIV_W'(1);
          rx_bit  <= '0;
        end
      end else if (rx_cnt != '0) begin
        rx_cnt <= rx_cnt - DIV_W'(1);
      end else begin
        rx_cnt <= div - DIV_W'(1);
        if ((rx_bit == '0 && rx_s) || rx_bit == LAST_B) rx_busy <= 1'b0;
        else begin
          if (rx_bit != '0) rx_shift <= {rx_s, rx_shift[DATA_W-1:1]};
          rx_bit <= rx_bit + BIT_W'(1);
        end
      end
    end

  // status flags
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_data <= '0; rrdy <= 1'b0; toe <= 1'b0; roe <= 1'b0; brk <= 1'b0; fe <= 1'b0;
    end else begin
      if (rx_end) rx_data <= rx_shift;
      rrdy <= rx_end | (rrdy & ~rd_rx);
      roe  <= (roe & ~wr_st) | (rx_end & rrdy & ~rd_rx);
      fe   <= (fe  & ~wr_st) | (rx_end & ~rx_s);
      brk  <= (brk & ~wr_st) | (rx_end & ~rx_s & (rx_shift == '0));
      toe  <= (toe & ~wr_st) | (wr_tx & txh_full);
    end

  // transmitter
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      txh <= '0; txh_full <= 1'b0; tx_busy <= 1'b0;
      tx_cnt <= '0; tx_bit <= '0; tx_sh <= '1;
    end else begin
      if (!tx_busy && txh_full) begin
        tx_busy  <= 1'b1;
        txh_full <= 1'b0;
        tx_cnt   <= div - DIV_W'(1);
        tx_bit   <= '0;
        tx_sh    <= {1'b1, txh, 1'b0};
      end else if (tx_busy) begin
        if (tx_cnt != '0) tx_cnt <= tx_cnt - DIV_W'(1);
        else begin
          tx_cnt <= div - DIV_W'(1);
          tx_sh  <= {1'b1, tx_sh[DATA_W+1:1]};
          if (tx_bit == LAST_B) tx_busy <= 1'b0;
          else tx_bit <= tx_bit + BIT_W'(1);
        end
      end
      if (wr_tx && !txh_full) begin
        txh      <= wdata[DATA_W-1:0];
        txh_full <= 1'b1;
      end
    end

  AST_TOE_ON_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tx && !trdy) |=> toe); // R6
  AST_RX_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && !rx_end) |=> !rrdy); // R7
  AST_STATUS_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st && !rx_end) |=> (!toe && !roe && !brk && !fe)); // R11
  AST_STATUS_WRITE_KEEPS_RRDY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st && !rx_end && !rd_rx) |=> $stable(rrdy)); // R11
  AST_TMT_LINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tmt |-> txd); // R5
  AST_TMT_NEEDS_TRDY: assert property (@(posedge clk) disable iff (!rst_n)
    tmt |-> trdy); // R5
  AST_BRK_WITH_FE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk) |-> fe); // R10
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl == '0) |-> !irq); // R12
endmodule

// File: tb/uart_regs_tb.sv
module uart_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BT = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, rxd = 1'b1;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic txd, irq;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  uart_regs dut_i (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
                   .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
    addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic drive_frame(input logic [7:0] d, input logic stopb);
    rxd = 1'b0; repeat (BT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; repeat (BT) @(negedge clk); end
    rxd = stopb; repeat (BT) @(negedge clk);
    rxd = 1'b1; repeat (4) @(negedge clk);
  endtask

  task automatic watch_tx(output logic [7:0] d, output int lowlen);
    lowlen = 0;
    while (txd !== 1'b0) @(negedge clk);
    while (txd === 1'b0) begin lowlen++; @(negedge clk); end
    repeat (5) @(negedge clk);
    for (int i = 0; i < 8; i++) begin d[i] = txd; if (i < 7) repeat (BT) @(negedge clk); end
    repeat (BT) @(negedge clk);
    chk("R4 stop bit", txd, 1);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd_reg(3'd2, v); chk("R2 status reset", v, 16'h060);
    chk("R13 PE zero", v[0], 0);
    rd_reg(3'd3, v); chk("R2 control reset", v, 0);
    rd_reg(3'd4, v); chk("R2 divisor reset", v, 16);
    chk("R12 irq low at reset", irq, 0);
  endtask

  task automatic t_regs;
    logic [15:0] v;
    wr_reg(3'd3, 16'h01FF); rd_reg(3'd3, v); chk("R1 control readback", v, 16'h01FF);
    wr_reg(3'd3, 16'h0000);
    wr_reg(3'd4, BT); rd_reg(3'd4, v); chk("R1 divisor readback", v, BT);
    rd_reg(3'd5, v); chk("R1 unused offset", v, 0);
    rd_reg(3'd1, v); chk("R1 tx offset reads zero", v, 0);
  endtask

  task automatic t_tx;
    logic [15:0] v; logic [7:0] d; int low;
    wr_reg(3'd1, 16'h00A5);
    rd_reg(3'd2, v); chk("R5 TRDY/TMT clear while full", v, 16'h000);
    watch_tx(d, low);
    chk("R4 start bit width", low, BT);
    chk("R4 data LSB first", d, 8'hA5);
    repeat (2*BT) @(negedge clk);
    rd_reg(3'd2, v); chk("R5 idle after frame", v, 16'h060);
    chk("R5 txd idle high", txd, 1);
  endtask

  task automatic t_toe;
    logic [15:0] v; logic [7:0] d; int low;
    wr_reg(3'd1, 16'h003D);
    wr_reg(3'd1, 16'h0055);
    rd_reg(3'd2, v); chk("R6 TOE and E set", v, 16'h150);
    watch_tx(d, low);
    chk("R6 overflow byte discarded", d, 8'h3D);
    repeat (2*BT) @(negedge clk);
    wr_reg(3'd2, 16'h0000);
    rd_reg(3'd2, v); chk("R11 status write clears TOE", v, 16'h060);
  endtask

  task automatic t_rx;
    logic [15:0] v;
    drive_frame(8'h5A, 1'b1);
    rd_reg(3'd2, v); chk("R7 RRDY set", v, 16'h0E0);
    chk("R3 RRDY at bit 7", v[7], 1);
    rd_reg(3'd0, v); chk("R7 received byte", v, 16'h005A);
    rd_reg(3'd2, v); chk("R7 read clears RRDY", v, 16'h060);
  endtask

  task automatic t_roe;
    logic [15:0] v;
    drive_frame(8'h11, 1'b1);
    drive_frame(8'h22, 1'b1);
    rd_reg(3'd2, v); chk("R8 ROE with E", v, 16'h1E8);
    rd_reg(3'd0, v); chk("R8 newest byte kept", v, 16'h0022);
    wr_reg(3'd2, 16'h0000);
    rd_reg(3'd2, v); chk("R11 clear after ROE", v, 16'h060);
  endtask

  task automatic t_fe;
    logic [15:0] v;
    drive_frame(8'h0F, 1'b0);
    rd_reg(3'd2, v); chk("R9 FE only", v, 16'h1E2);
    rd_reg(3'd0, v); chk("R9 byte stored", v, 16'h000F);
    wr_reg(3'd2, 16'h0000);
  endtask

  task automatic t_brk;
    logic [15:0] v;
    drive_frame(8'h00, 1'b0);
    rd_reg(3'd2, v); chk("R10 BRK and FE", v, 16'h1E6);
    wr_reg(3'd2, 16'hFFFF);
    rd_reg(3'd2, v); chk("R11 write keeps RRDY", v, 16'h0E0);
    rd_reg(3'd0, v);
    rd_reg(3'd2, v); chk("R13 PE stays zero", v[0], 0);
  endtask

  task automatic t_irq;
    logic [15:0] v;
    wr_reg(3'd3, 16'h0080);
    chk("R12 irq masked source clear", irq, 0);
    drive_frame(8'h77, 1'b1);
    chk("R12 irq on RRDY", irq, 1);
    rd_reg(3'd0, v);
    chk("R12 irq drops after read", irq, 0);
    wr_reg(3'd3, 16'h0040);
    chk("R12 irq on TRDY", irq, 1);
    wr_reg(3'd3, 16'h0100);
    chk("R12 irq E disabled path clear", irq, 0);
    wr_reg(3'd3, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset; t_regs; t_tx; t_toe; t_rx; t_roe; t_fe; t_brk; t_irq;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule